// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block sits between a processor's 32-bit word load/store port and a slow main memory that moves whole lines. It keeps 256 lines of 16 bytes (4 KB). Each line has a tag, a valid flag and a dirty flag. A byte address is split into a 4-bit line offset in bits 3:0, an 8-bit line index in bits 11:4 and a 20-bit tag in bits 31:12. The index is therefore the block address (address shifted right by four) modulo 256. A lookup that finds a valid line with an equal tag answers in the same cycle. Anything else stalls the requester while the controller moves lines over the memory port.

Stores are kept in the cache and are not sent on to memory. The changed line is marked dirty. When a miss lands on a dirty line, the old line goes back to memory first, at the address rebuilt from its stored tag and the index. The new line is fetched only after that, so the stall is about twice as long. Store misses allocate: the line is fetched, then the word is merged in.

The requester raises `req_valid` and holds the command, address and store data steady until it sees `req_ready` high at a clock edge. Memory transfers use `mem_req`, which stays high until a one-cycle `mem_ready` pulse. The memory may take any number of cycles to answer.

Top module: `dcache_top`

## Requirements
- R1: After reset every line is invalid. No memory transfer is pending, `req_ready` is low when idle, and the first access to any address misses.
- R2: Index bits are address bits 11:4 and tag bits are 31:12. Two addresses with the same index and different tags displace each other. Addresses in the same 16-byte line share one entry.
- R3: A lookup hits only if the indexed line is valid and its stored tag equals the address tag. Otherwise it misses, even when the line is valid.
- R4: On a miss the line is read from memory at the line-aligned address {tag, index, 4'h0}. It then becomes valid with the new tag, and the requested word is returned.
- R5: A hit raises `req_ready` in the cycle the request is presented, with no memory transfer. A miss holds `req_ready` low until the refill is done, for at least the memory latency.
- R6: A store hit updates only the cached word. It starts no memory transfer and marks the line dirty. A later load returns the stored value.
- R7: A miss on a valid dirty line first writes the old 16 bytes to {old tag, index, 4'h0} with `mem_we` high. Only then does it read the new line, so the stall is at least twice the memory latency.
- R8: A miss on an invalid line, or on a valid clean line, performs no write-back.
- R9: A store miss fetches the line (after a write-back if the victim is dirty) and merges the word. The line is left valid and dirty, so its later eviction writes the stored word back.
- R10: Requests are word aligned (address bits 1:0 are zero). The word at offset 4k occupies bits 32k+31:32k of the 128-bit line on the memory port (little-endian word order).
- R11: A line refilled for a load is clean. Evicting it later causes no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Word-aligned byte address |
| req_wdata | input | 32 | Store data |
| req_ready | output | 1 | Request completes at this clock edge |
| rsp_rdata | output | 32 | Load data, valid while `req_ready` is high |
| mem_req | output | 1 | Line transfer requested |
| mem_we | output | 1 | 1 = write-back, 0 = refill |
| mem_addr | output | 32 | Line-aligned memory address |
| mem_wdata | output | 128 | Line data being written back |
| mem_rdata | input | 128 | Line data returned by memory |
| mem_ready | input | 1 | Transfer done at this clock edge |

## Verification
A wrong tag, valid or dirty flag does not show up in the cycle it goes wrong. It shows up on the next access to that index. A lost dirty flag makes a later conflict miss skip its write-back, and a following load then returns stale memory data. A stray dirty flag produces an unexpected write transaction on the memory port. A wrong tag turns a hit into a long stall, or a miss into a one-cycle answer with foreign data. The bench therefore follows every store with a conflicting load and a reload of the original address. It predicts each memory transaction, each load word and the stall length class of every access from its own cache model.

// File: rtl/dcache_pkg.sv
// Package: shared constants and the miss-controller state type.
// Assumes a 32-bit byte address and 32-bit words throughout.
package dcache_pkg;
    localparam int ADDR_W = 32;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        ST_LOOKUP    = 2'd0,
        ST_WRITEBACK = 2'd1,
        ST_REFILL    = 2'd2,
        ST_RESPOND   = 2'd3
    } ctrl_state_t;
endpackage

// File: rtl/dcache_tag_store.sv
// Tag store: per-line tag, valid and dirty flags and the hit compare.
// Assumes one lookup per cycle. A fill and a store hit never share a cycle.
module dcache_tag_store #(
    parameter int NUM_LINES = 256,
    parameter int IDX_W     = 8,
    parameter int TAG_W     = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic [TAG_W-1:0] tag,
    input  logic             fill_we,
    input  logic             fill_dirty,
    input  logic             store_we,
    output logic             hit,
    output logic             victim_dirty,
    output logic [TAG_W-1:0] victim_tag
);
    logic [NUM_LINES-1:0] valid_q;
    logic [NUM_LINES-1:0] dirty_q;
    logic [TAG_W-1:0]     tag_q [NUM_LINES];

    // Flag update: reset clears, a fill installs, a store hit dirties.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (fill_we) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= fill_dirty;
        end else if (store_we) begin
            dirty_q[idx] <= 1'b1;
        end
    end

    // Tag write on fill. Tags need no reset because valid guards them.
    always_ff @(posedge clk) begin
        if (fill_we) begin
            tag_q[idx] <= tag;
        end
    end

    // Lookup: compare the stored tag and report the victim state.
    always_comb begin
        victim_tag   = tag_q[idx];
        hit          = valid_q[idx] && (tag_q[idx] == tag);
        victim_dirty = valid_q[idx] && dirty_q[idx];
    end

    AST_DIRTY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (dirty_q & ~valid_q) == '0); // R6
    AST_FILL_LEAVES_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        fill_we |=> hit || !$stable(idx) || !$stable(tag)); // R4
endmodule

// File: rtl/dcache_data_store.sv
// Data store: one full line per entry, whole-line fill and single-word merge.
// Assumes word-granular stores. Data needs no reset because valid guards it.
module dcache_data_store #(
    parameter int NUM_LINES = 256,
    parameter int IDX_W     = 8,
    parameter int WORDS     = 4,
    parameter int WSEL_W    = 2,
    parameter int WORD_W    = 32
) (
    input  logic                    clk,
    input  logic [IDX_W-1:0]        idx,
    input  logic [WSEL_W-1:0]       word_sel,
    input  logic                    fill_we,
    input  logic [WORDS*WORD_W-1:0] fill_line,
    input  logic                    store_we,
    input  logic [WORD_W-1:0]       store_word,
    output logic [WORDS*WORD_W-1:0] line_out,
    output logic [WORD_W-1:0]       word_out
);
    localparam int LINE_W = WORDS * WORD_W;

    logic [LINE_W-1:0] line_q [NUM_LINES];
    logic [WORD_W-1:0] words  [WORDS];

    // Line write: a refill replaces the entry, a store merges one word.
    always_ff @(posedge clk) begin
        if (fill_we) begin
            line_q[idx] <= fill_line;
        end else if (store_we) begin
            line_q[idx][word_sel*WORD_W +: WORD_W] <= store_word;
        end
    end

    assign line_out = line_q[idx];

    // Word slicing: word k sits at bits 32k+31:32k (little-endian order).
    for (genvar k = 0; k < WORDS; k++) begin : g_word
        assign words[k] = line_out[k*WORD_W +: WORD_W];
    end

    assign word_out = words[word_sel];
endmodule

// File: rtl/dcache_ctrl.sv
// Miss controller: decides hit completion, write-back and refill order.
// Assumes the requester holds its command steady until req_ready is high.
module dcache_ctrl
    import dcache_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_write,
    input  logic hit,
    input  logic victim_dirty,
    input  logic mem_ready,
    output logic req_ready,
    output logic store_we,
    output logic fill_we,
    output logic mem_req,
    output logic mem_we
);
    ctrl_state_t st_q, st_d;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_LOOKUP;
        else        st_q <= st_d;
    end

    // Next state: dirty victims go back to memory before the refill.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_LOOKUP:    if (req_valid && !hit)
                              st_d = victim_dirty ? ST_WRITEBACK : ST_REFILL;
            ST_WRITEBACK: if (mem_ready) st_d = ST_REFILL;
            ST_REFILL:    if (mem_ready) st_d = ST_RESPOND;
            ST_RESPOND:   st_d = ST_LOOKUP;
            default:      st_d = ST_LOOKUP;
        endcase
    end

    // Outputs: ready only on a hit, in lookup or right after a refill.
    always_comb begin
        req_ready = (st_q == ST_LOOKUP || st_q == ST_RESPOND) && req_valid && hit;
        store_we  = req_ready && req_write;
        fill_we   = (st_q == ST_REFILL) && mem_ready;
        mem_req   = (st_q == ST_WRITEBACK) || (st_q == ST_REFILL);
        mem_we    = (st_q == ST_WRITEBACK);
    end

    AST_RESPOND_HITS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RESPOND && req_valid) |-> hit); // R4
    AST_WB_THEN_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_ready) |=> (mem_req && !mem_we)); // R7
endmodule

// File: rtl/dcache_top.sv
// Direct-mapped write-back data cache top: splits the address, links stores.
// Assumes aligned word requests held until ready, and a line-wide memory port.
module dcache_top
    import dcache_pkg::*;
#(
    parameter int NUM_LINES  = 256,
    parameter int LINE_BYTES = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [WORD_W-1:0]       req_wdata,
    output logic                    req_ready,
    output logic [WORD_W-1:0]       rsp_rdata,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [LINE_BYTES*8-1:0] mem_wdata,
    input  logic [LINE_BYTES*8-1:0] mem_rdata,
    input  logic                    mem_ready
);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = $clog2(NUM_LINES);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int WORDS  = LINE_BYTES / (WORD_W / 8);
    localparam int WSEL_W = $clog2(WORDS);

    logic [IDX_W-1:0]  req_idx;
    logic [TAG_W-1:0]  req_tag;
    logic [WSEL_W-1:0] word_sel;
    logic [TAG_W-1:0]  victim_tag;
    logic              hit, victim_dirty, store_we, fill_we;

    assign req_idx  = req_addr[OFF_W +: IDX_W];
    assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];
    assign word_sel = req_addr[2 +: WSEL_W];

    dcache_tag_store #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n), .idx(req_idx), .tag(req_tag),
        .fill_we(fill_we), .fill_dirty(req_write), .store_we(store_we),
        .hit(hit), .victim_dirty(victim_dirty), .victim_tag(victim_tag)
    );

    dcache_data_store #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .WORDS(WORDS),
                        .WSEL_W(WSEL_W), .WORD_W(WORD_W)) u_data (
        .clk(clk), .idx(req_idx), .word_sel(word_sel),
        .fill_we(fill_we), .fill_line(mem_rdata),
        .store_we(store_we), .store_word(req_wdata),
        .line_out(mem_wdata), .word_out(rsp_rdata)
    );

    dcache_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .hit(hit), .victim_dirty(victim_dirty), .mem_ready(mem_ready),
        .req_ready(req_ready), .store_we(store_we), .fill_we(fill_we),
        .mem_req(mem_req), .mem_we(mem_we)
    );

    // Memory address: the victim's rebuilt address on write-back, else the request line.
    assign mem_addr = {(mem_we ? victim_tag : req_tag), req_idx, {OFF_W{1'b0}}};

    AST_MISS_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !hit) |-> !req_ready); // R5
    AST_STORE_HIT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_write) |-> !mem_req); // R6
    AST_MEM_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> $stable(mem_addr)); // R7
    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_addr[1:0] == 2'b00)); // R10
endmodule

// File: tb/dcache_top_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver predicts from its own cache model, monitors compare.
module dcache_top_tb;
    localparam int MEM_LAT = 100;
    localparam int WDOG    = 150000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0, req_write = 1'b0;
    logic [31:0]  req_addr = '0, req_wdata = '0;
    logic         req_ready;
    logic [31:0]  rsp_rdata;
    logic         mem_req, mem_we;
    logic [31:0]  mem_addr;
    logic [127:0] mem_wdata;
    logic [127:0] mem_rdata = '0;
    logic         mem_ready = 1'b0;

    int checks = 0, errors = 0, cycles = 0, mcnt = 0;

    typedef struct { bit we; logic [31:0] addr; logic [127:0] data; string tag; } mx_t;
    typedef struct { logic [31:0] data; string tag; } rx_t;
    mx_t mem_exp[$];
    rx_t rd_exp[$];

    logic [31:0] mem_w  [int unsigned];
    logic [31:0] gold_w [int unsigned];
    bit          gv [256];
    bit          gd [256];
    logic [19:0] gt [256];

    always #2 clk = ~clk;

    dcache_top u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_rdata(rsp_rdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready)
    );

    function automatic logic [31:0] pattern(input logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h5A17C0DE;
    endfunction

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return mem_w.exists(a) ? mem_w[a] : pattern(a);
    endfunction

    function automatic logic [31:0] gold_word(input logic [31:0] a);
        return gold_w.exists(a) ? gold_w[a] : pattern(a);
    endfunction

    function automatic logic [127:0] gold_line(input logic [31:0] base);
        logic [127:0] l;
        for (int k = 0; k < 4; k++) l[32*k +: 32] = gold_word(base + 32'(4*k));
        return l;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Memory model: answers each held request after MEM_LAT cycles.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ready <= 1'b0;
            mcnt      <= 0;
        end else if (mem_ready) begin
            mem_ready <= 1'b0;
            mcnt      <= 0;
        end else if (mem_req) begin
            if (mcnt == MEM_LAT - 1) begin
                mem_ready <= 1'b1;
                if (mem_we) begin
                    for (int k = 0; k < 4; k++)
                        mem_w[mem_addr + 32'(4*k)] = mem_wdata[32*k +: 32];
                end else begin
                    for (int k = 0; k < 4; k++)
                        mem_rdata[32*k +: 32] <= mem_word(mem_addr + 32'(4*k));
                end
            end else begin
                mcnt <= mcnt + 1;
            end
        end
    end

    // Memory monitor: each completed transfer against the predicted one.
    always @(negedge clk) begin
        if (rst_n && mem_req && mem_ready) begin
            if (mem_exp.size() == 0) begin
                chk(0, "R8", "unexpected memory transfer addr", 128'(mem_addr), 128'(0));
            end else begin
                mx_t e;
                e = mem_exp.pop_front();
                chk(mem_we == e.we, e.tag, "transfer direction", 128'(mem_we), 128'(e.we));
                chk(mem_addr == e.addr, e.tag, "transfer address", 128'(mem_addr), 128'(e.addr));
                if (e.we) chk(mem_wdata == e.data, e.tag, "write-back line", mem_wdata, e.data);
            end
        end
    end

    // Load monitor: returned word against the predicted word.
    always @(negedge clk) begin
        if (rst_n && req_valid && req_ready && !req_write) begin
            if (rd_exp.size() == 0) begin
                chk(0, "R4", "unexpected load completion", 128'(rsp_rdata), 128'(0));
            end else begin
                rx_t e;
                e = rd_exp.pop_front();
                chk(rsp_rdata == e.data, e.tag, "load data", 128'(rsp_rdata), 128'(e.data));
            end
        end
    end

    // Driver: predicts the access in the bench's own model, then runs it.
    task automatic access(input bit wr, input logic [31:0] a, input logic [31:0] wd,
                          input string tag);
        logic [7:0]  idx;
        logic [19:0] tg;
        int kind, stall;
        idx = a[11:4];
        tg  = a[31:12];
        if (gv[idx] && gt[idx] == tg) begin
            kind = 0;
        end else begin
            if (gv[idx] && gd[idx]) begin
                kind = 2;
                mem_exp.push_back('{1'b1, {gt[idx], idx, 4'h0}, gold_line({gt[idx], idx, 4'h0}), tag});
            end else begin
                kind = 1;
            end
            mem_exp.push_back('{1'b0, {tg, idx, 4'h0}, 128'(0), tag});
            gv[idx] = 1'b1;
            gt[idx] = tg;
            gd[idx] = 1'b0;
        end
        if (wr) begin
            gd[idx] = 1'b1;
            gold_w[a] = wd;
        end else begin
            rd_exp.push_back('{gold_word(a), tag});
        end
        @(posedge clk); #1;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        stall = 0;
        forever begin
            @(negedge clk);
            if (req_ready) break;
            stall++;
        end
        @(posedge clk); #1;
        req_valid = 1'b0; req_write = 1'b0;
        if (kind == 0)
            chk(stall == 0, tag, "hit stall cycles", 128'(stall), 128'(0));
        else if (kind == 1)
            chk(stall >= MEM_LAT && stall < 2*MEM_LAT, tag, "clean miss stall cycles",
                128'(stall), 128'(MEM_LAT));
        else
            chk(stall >= 2*MEM_LAT && stall < 3*MEM_LAT, tag, "dirty miss stall cycles",
                128'(stall), 128'(2*MEM_LAT));
        chk(mem_exp.size() == 0, tag, "pending memory transfers", 128'(mem_exp.size()), 128'(0));
        chk(rd_exp.size() == 0, tag, "pending loads", 128'(rd_exp.size()), 128'(0));
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cycles, WDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin gv[i] = 0; gd[i] = 0; gt[i] = '0; end
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset, nothing requested.
        chk(req_ready == 1'b0, "R1", "ready after reset", 128'(req_ready), 128'(0));
        chk(mem_req == 1'b0, "R1", "mem_req after reset", 128'(mem_req), 128'(0));

        access(0, 32'h1001_0048, '0, "R1");   // first access misses, clean refill (R4)
        access(0, 32'h1001_004C, '0, "R3");   // same line hits
        access(0, 32'h1001_0040, '0, "R10");  // word 0 of the line
        access(0, 32'h1001_0044, '0, "R10");  // word 1 of the line
        access(0, 32'h7FFF_EFFC, '0, "R4");   // index FF refill
        access(0, 32'h2537_1044, '0, "R2");   // same index, other tag: displaces
        access(0, 32'h1001_0048, '0, "R3");   // valid line, tag mismatch: miss (R11 clean)
        access(1, 32'h1001_004C, 32'hCAFE_0001, "R6"); // store hit, no memory traffic
        access(0, 32'h1001_004C, '0, "R6");   // reads stored word
        access(0, 32'h2537_1044, '0, "R7");   // dirty victim: write-back then refill
        access(0, 32'h1001_004C, '0, "R7");   // memory now holds the stored word
        access(1, 32'h3000_0008, 32'hBEEF_1234, "R9"); // store miss, write-allocate
        access(0, 32'h3000_0008, '0, "R9");   // merged word readable
        access(0, 32'h4000_0000, '0, "R9");   // eviction writes stored word back
        access(0, 32'h3000_0008, '0, "R9");   // refetch returns stored value
        access(0, 32'h7FFF_EFF0, '0, "R5");   // index FF still resident: one-cycle hit
        access(0, 32'h9000_0040, '0, "R8");   // clean victim at index 04: no write-back
        access(0, 32'h1001_004C, '0, "R11");  // clean victim again: no write-back

        repeat (4) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule